// File: doc/BRIEF.md
# Multi-Mode Clock-Enable Divider

This block divides a clock-enable stream. It runs on a fast system clock and produces a registered divided waveform on `div_out`. A configuration write supplies four things: a divider field, a 3-bit encoding mode, a source code and an inversion flag. The mode sets how the field becomes the real division ratio. The source code picks one of four incoming tick streams. The divider advances only on cycles when the selected stream is high, so a stream that is held high counts plain clock cycles.

Settings are kept in a shadow register. The live divider loads them only at the end of its current output period, so no high phase is ever cut short. A bank of gate bits can close the output. While any gate bit is low the output stays low, the period restarts, and pending settings are taken over at once. The decoded ratio is presented on `ratio_rd`, so software can work out the resulting rate.

Top module: `clkdiv_multimode`

## Requirements
- R1: After the synchronous active-high reset, `div_out` is 0 and `ratio_rd` is 1. The live settings are ratio 1, source 0 and no inversion.
- R2: On the cycle after a clock edge with `cfg_we` high, `ratio_rd` shows the ratio decoded from that write. With no write it holds its value.
- R3: The decoded ratio depends on `cfg_mode` and the field N:
  - mode 0 gives N+1
  - mode 1 gives 2N
  - mode 2 gives 2^N, clamped to 2^(FIELD_W+1) when N is FIELD_W+1 or more
  - mode 3 gives 2(N+1)
  - mode 4 gives N
  - modes 5 to 7 act as mode 0
  - a result of zero becomes 1
- R4: Source codes 0, 1 and 2 select tick streams 0, 1 and 2. Code 4 selects stream 3. Codes 3, 5, 6 and 7 select stream 0. The divider position advances only on cycles when the selected stream is high.
- R5: For a live ratio R of 2 or more, a period is R ticks at positions 0 to R-1. The divider output is high at positions 0 to floor(R/2)-1 and low at the rest. `div_out` shows the level of a cycle's position one cycle later.
- R6: With a live ratio of 1, `div_out` equals the selected tick stream delayed by one cycle.
- R7: New settings (ratio, source, inversion) become live only on a tick at the last position of the current period. A write in mid-period does not change the period in progress.
- R8: While any bit of `gate_en` is low, `div_out` is 0 on the next cycle, the position returns to 0, and the shadow settings become live.
- R9: When the live inversion flag is set and the gate is open, `div_out` is the complement of the divider level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_field | input | FIELD_W | Divider field N |
| cfg_mode | input | 3 | Field encoding mode (R3) |
| cfg_src | input | 3 | Tick source code (R4) |
| cfg_inv | input | 1 | Output inversion flag |
| src_tick | input | 4 | Candidate tick streams |
| gate_en | input | NUM_GATE | Gate bits; output runs only when all are set |
| div_out | output | 1 | Registered divided output |
| ratio_rd | output | FIELD_W+2 | Decoded ratio of the latest write |

## Verification
The hardest case to reach from the ports is a write that lands partway through a long period. The new ratio must wait for the last tick of the old period, and how long that takes depends on how sparse the selected stream is. The bench reaches this case by writing a new ratio a few cycles into a ratio-8 period. It also switches between tick streams of different densities, including the stream behind the remapped code 4. It then closes the gate while a write is pending, which forces an immediate reload. A per-cycle reference model follows every one of these transitions.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int NUM_SRC = 4;
  localparam int SEL_W   = 2;

  typedef enum logic [2:0] {
    MODE_PLUS1     = 3'd0,
    MODE_DOUBLE    = 3'd1,
    MODE_EXP       = 3'd2,
    MODE_PLUS1_DBL = 3'd3,
    MODE_NONZERO   = 3'd4
  } div_mode_e;

  // Register code that selects stream i: the top stream uses code 4.
  function automatic logic [2:0] src_code(input int i);
    return (i == NUM_SRC - 1) ? 3'd4 : 3'(i);
  endfunction

endpackage

// File: rtl/clkdiv_ratio_decode.sv
module clkdiv_ratio_decode
  import clkdiv_pkg::*;
#(
  parameter int FIELD_W = 15,
  parameter int RATIO_W = FIELD_W + 2
) (
  input  logic [FIELD_W-1:0] field,
  input  logic [2:0]         mode,
  output logic [RATIO_W-1:0] ratio
);

  localparam int EXP_MAX = RATIO_W - 1;

  logic [RATIO_W-1:0] fext;
  logic [RATIO_W-1:0] raw;

  always_comb begin
    fext = RATIO_W'(field);
    unique case (div_mode_e'(mode))
      MODE_PLUS1:     raw = fext + 1'b1;
      MODE_DOUBLE:    raw = fext << 1;
      MODE_EXP:       raw = (32'(field) >= EXP_MAX) ? (RATIO_W'(1) << EXP_MAX)
                                                    : (RATIO_W'(1) << field);
      MODE_PLUS1_DBL: raw = (fext + 1'b1) << 1;
      MODE_NONZERO:   raw = fext;
      default:        raw = fext + 1'b1;
    endcase
    ratio = (raw == '0) ? RATIO_W'(1) : raw;
  end

endmodule

// File: rtl/clkdiv_src_select.sv
module clkdiv_src_select
  import clkdiv_pkg::*;
(
  input  logic [2:0]       code,
  output logic [SEL_W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (code == src_code(i)) idx = SEL_W'(i);
    end
  end

endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
  import clkdiv_pkg::*;
#(
  parameter int RATIO_W = 17
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic               gate_open,
  input  logic [RATIO_W-1:0] sh_ratio,
  input  logic [SEL_W-1:0]   sh_sel,
  input  logic               sh_inv,
  output logic               div_out
);

  logic [RATIO_W-1:0] act_ratio;
  logic [SEL_W-1:0]   act_sel;
  logic               act_inv;
  logic [RATIO_W-1:0] pos;

  logic tick, last, level, out_nxt, reload;

  always_comb begin
    tick    = src_tick[act_sel];
    last    = (pos == act_ratio - 1'b1);
    level   = (act_ratio == RATIO_W'(1)) ? tick : (pos < (act_ratio >> 1));
    out_nxt = gate_open & (level ^ act_inv);
    reload  = !gate_open || (tick && last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_out   <= 1'b0;
      pos       <= '0;
      act_ratio <= RATIO_W'(1);
      act_sel   <= '0;
      act_inv   <= 1'b0;
    end else begin
      div_out <= out_nxt;
      if (reload) begin
        pos       <= '0;
        act_ratio <= sh_ratio;
        act_sel   <= sh_sel;
        act_inv   <= sh_inv;
      end else if (tick) begin
        pos <= pos + 1'b1;
      end
    end
  end

endmodule

// File: rtl/clkdiv_multimode.sv
module clkdiv_multimode
  import clkdiv_pkg::*;
#(
  parameter int FIELD_W  = 15,
  parameter int NUM_GATE = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [FIELD_W-1:0]    cfg_field,
  input  logic [2:0]            cfg_mode,
  input  logic [2:0]            cfg_src,
  input  logic                  cfg_inv,
  input  logic [NUM_SRC-1:0]    src_tick,
  input  logic [NUM_GATE-1:0]   gate_en,
  output logic                  div_out,
  output logic [FIELD_W+1:0]    ratio_rd
);

  localparam int RATIO_W = FIELD_W + 2;

  logic [RATIO_W-1:0] dec_ratio;
  logic [SEL_W-1:0]   dec_sel;
  logic [SEL_W-1:0]   sh_sel;
  logic               sh_inv;

  clkdiv_ratio_decode #(.FIELD_W(FIELD_W), .RATIO_W(RATIO_W)) u_decode (
    .field (cfg_field),
    .mode  (cfg_mode),
    .ratio (dec_ratio)
  );

  clkdiv_src_select u_select (
    .code (cfg_src),
    .idx  (dec_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_rd <= RATIO_W'(1);
      sh_sel   <= '0;
      sh_inv   <= 1'b0;
    end else if (cfg_we) begin
      ratio_rd <= dec_ratio;
      sh_sel   <= dec_sel;
      sh_inv   <= cfg_inv;
    end
  end

  clkdiv_core #(.RATIO_W(RATIO_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .src_tick  (src_tick),
    .gate_open (&gate_en),
    .sh_ratio  (ratio_rd),
    .sh_sel    (sh_sel),
    .sh_inv    (sh_inv),
    .div_out   (div_out)
  );

endmodule

// File: rtl/clkdiv_multimode_chk.sv
module clkdiv_multimode_chk #(
  parameter int FIELD_W  = 15,
  parameter int NUM_GATE = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_we,
  input logic [FIELD_W-1:0]  cfg_field,
  input logic [2:0]          cfg_mode,
  input logic [NUM_GATE-1:0] gate_en,
  input logic                div_out,
  input logic [FIELD_W+1:0]  ratio_rd
);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (div_out == 1'b0 && ratio_rd == (FIELD_W+2)'(1)));

  assert_readback_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(ratio_rd));

  assert_plus_one_decode_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_mode == 3'd0) |=> (ratio_rd == (FIELD_W+2)'($past(cfg_field)) + 1'b1));

  assert_ratio_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    ratio_rd != '0);

  assert_gate_closed_R8: assert property (@(posedge clk) disable iff (rst)
    (gate_en != '1) |=> (div_out == 1'b0));

endmodule

bind clkdiv_multimode clkdiv_multimode_chk #(.FIELD_W(FIELD_W), .NUM_GATE(NUM_GATE)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .cfg_field (cfg_field),
  .cfg_mode  (cfg_mode),
  .gate_en   (gate_en),
  .div_out   (div_out),
  .ratio_rd  (ratio_rd)
);

// File: tb/tb_clkdiv_multimode.sv
module tb_clkdiv_multimode;

  localparam int FIELD_W  = 15;
  localparam int NUM_GATE = 4;
  localparam int RW       = FIELD_W + 2;

  logic                clk = 1'b0;
  logic                rst;
  logic                cfg_we;
  logic [FIELD_W-1:0]  cfg_field;
  logic [2:0]          cfg_mode;
  logic [2:0]          cfg_src;
  logic                cfg_inv;
  logic [3:0]          src_tick;
  logic [NUM_GATE-1:0] gate_en;
  logic                div_out;
  logic [RW-1:0]       ratio_rd;

  always #4 clk = ~clk;

  clkdiv_multimode #(.FIELD_W(FIELD_W), .NUM_GATE(NUM_GATE)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_field(cfg_field),
    .cfg_mode(cfg_mode), .cfg_src(cfg_src), .cfg_inv(cfg_inv),
    .src_tick(src_tick), .gate_en(gate_en), .div_out(div_out), .ratio_rd(ratio_rd)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    run_cmp = 1'b0;
  int    cyc = 0;

  // Reference model state
  int m_ratio, m_sel, m_inv, m_pos, m_out;
  int sh_ratio, sh_sel, sh_inv;

  function automatic int dec(input int mode, input int field);
    int r;
    case (mode)
      1: r = 2 * field;
      2: r = (field >= 16) ? 65536 : (1 << field);
      3: r = 2 * (field + 1);
      4: r = field;
      default: r = field + 1;
    endcase
    if (r == 0) r = 1;
    return r;
  endfunction

  function automatic int sel_of(input int code);
    if (code <= 2) return code;
    if (code == 4) return 3;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Tick stream patterns
  always @(negedge clk) begin
    cyc <= cyc + 1;
    src_tick[0] <= 1'b1;
    src_tick[1] <= ((cyc % 2) == 0);
    src_tick[2] <= ((cyc % 3) == 0);
    src_tick[3] <= ((cyc % 7) != 2);
  end

  // Cycle-by-cycle reference model
  always @(posedge clk) begin
    if (rst) begin
      m_ratio = 1; m_sel = 0; m_inv = 0; m_pos = 0; m_out = 0;
      sh_ratio = 1; sh_sel = 0; sh_inv = 0;
    end else begin
      int tk, gate, lvl;
      tk   = src_tick[m_sel];
      gate = (gate_en == '1);
      lvl  = (m_ratio == 1) ? tk : (m_pos < m_ratio / 2);
      m_out = gate ? (lvl ^ m_inv) : 0;
      if (!gate || (tk && m_pos == m_ratio - 1)) begin
        m_pos = 0; m_ratio = sh_ratio; m_sel = sh_sel; m_inv = sh_inv;
      end else if (tk) begin
        m_pos = m_pos + 1;
      end
      if (cfg_we) begin
        sh_ratio = dec(cfg_mode, cfg_field);
        sh_sel   = sel_of(cfg_src);
        sh_inv   = cfg_inv;
      end
    end
  end

  always @(negedge clk) begin
    if (run_cmp) begin
      chk(div_out === 1'(m_out), cur_req, div_out, m_out);
      chk(ratio_rd === RW'(sh_ratio), "R2", ratio_rd, sh_ratio);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int mode, input int field, input int src, input int inv);
    cfg_mode  = 3'(mode);
    cfg_field = FIELD_W'(field);
    cfg_src   = 3'(src);
    cfg_inv   = 1'(inv);
    cfg_we    = 1'b1;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic wr_dec(input int mode, input int field);
    wr(mode, field, 0, 0);
    chk(ratio_rd === RW'(dec(mode, field)), "R3", ratio_rd, dec(mode, field));
    idle(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_field = '0; cfg_mode = '0; cfg_src = '0;
    cfg_inv = 1'b0; gate_en = '1; src_tick = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(div_out === 1'b0, "R1", div_out, 0);
    chk(ratio_rd === RW'(1), "R1", ratio_rd, 1);
    run_cmp = 1'b1;

    // R6: ratio one, always-high source then alternating source
    cur_req = "R6";
    idle(8);
    wr(0, 0, 1, 0);
    idle(20);

    // R3: decode of every mode incl. clamps and zero fix-up
    cur_req = "R3";
    wr_dec(0, 4);
    wr_dec(1, 0);
    wr_dec(1, 7);
    wr_dec(2, 3);
    wr_dec(2, 20);
    wr_dec(3, 320);
    wr_dec(4, 0);
    wr_dec(4, 9);
    wr_dec(6, 5);
    wr_dec(2, 0);

    // R5: odd ratio 5 on the always-high stream; high phase is 2 cycles
    cur_req = "R5";
    wr(0, 4, 0, 0);
    idle(12);
    begin
      int hi = 0;
      bit prev = div_out;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (div_out && !prev) break;
        prev = div_out;
      end
      for (int k = 0; k < 5; k++) begin
        if (div_out) hi++;
        @(negedge clk);
      end
      chk(hi == 2, "R5", hi, 2);
    end
    idle(20);

    // R4: stream behind code 4, fallback codes, sparse stream
    cur_req = "R4";
    wr(0, 1, 4, 0);
    idle(30);
    wr(0, 2, 6, 0);
    idle(20);
    wr(0, 0, 2, 0);
    idle(20);
    wr(0, 3, 1, 0);
    idle(30);

    // R7: mid-period write must wait for period end
    cur_req = "R7";
    wr(1, 4, 0, 0);
    idle(19);
    idle(3);
    wr(0, 2, 0, 0);
    idle(30);
    wr(1, 5, 2, 0);
    idle(40);
    wr(0, 1, 0, 0);
    idle(40);

    // R8: gating with a pending write
    cur_req = "R8";
    wr(0, 9, 0, 0);
    idle(15);
    gate_en[2] = 1'b0;
    wr(0, 2, 0, 0);
    idle(4);
    chk(div_out === 1'b0, "R8", div_out, 0);
    gate_en = '1;
    idle(20);
    gate_en[0] = 1'b0;
    idle(2);
    chk(div_out === 1'b0, "R8", div_out, 0);
    gate_en = '1;
    idle(12);

    // R9: inversion on ratio 4 and on ratio 1
    cur_req = "R9";
    wr(0, 3, 0, 1);
    idle(30);
    wr(0, 0, 1, 1);
    idle(20);

    run_cmp = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule